// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block is the interrupt-message half of a PCI function's MSI-X capability. It keeps a small vector table. Each entry holds a 64-bit message address, a 32-bit message data word and a per-vector mask. It also keeps a pending-bit array and the capability's control byte, which carries the enable and function-wide mask bits. Software reaches the table and the pending array through dword accesses on a 4 KiB memory window. It reaches the control byte through byte writes.

The device raises a per-vector event line when it wants an interrupt. If the vector can deliver, the block issues a one-cycle message-write request that carries the entry's address and data. If the vector is masked, either by its own mask or by the function mask, the event is latched in the pending array. The latched message is replayed once the vector becomes deliverable again. The device can retire a vector through its "unused" line, which drops any pending bit it holds. While MSI-X is enabled, all four legacy INTx lines are forced low.

Top module: `msix_table_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00. Every entry's vector-control word reads 0x0000_0001 (masked). All other table words and the pending array read 0. No message is requested.
- R2: Entry v occupies window offsets 16v to 16v+15. Its words are message address low (+0x0), message address high (+0x4), message data (+0x8) and vector control (+0xC, bit 0 = mask). Address bits 1:0 are ignored. Byte lane k of a dword holds the byte at offset +k (little-endian).
- R3: Table offsets below 0x800 that fall beyond the last entry read 0, and writes to them change nothing. Offset 0x800 reads the pending array, with bit v for vector v. Writes to the 0x800 half of the window change nothing.
- R4: The control byte has bit 7 = MSI-X enable and bit 6 = function mask. Its other bits read 0 and ignore writes. The byte changes only on a control write.
- R5: An event on vector v, while enable is 1, the function mask is 0 and v's mask is 0, produces msg_valid_o high for exactly the cycle after the clock edge that samples the event. The request carries address {addr_hi, addr_lo} and data of entry v.
- R6: An event on an enabled vector whose own mask or the function mask is set sends no message and sets that vector's pending bit. The function mask blocks delivery even when the vector mask is 0.
- R7: When a pending vector becomes deliverable, through a vector unmask or a clear of the function mask, its message is sent and its pending bit cleared. When several vectors are deliverable at once, messages go out one per cycle, lowest index first.
- R8: A high unused_i[v] clears v's pending bit and discards a same-cycle event on v. A later unmask of v then sends nothing.
- R9: Events that arrive while enable is 0 are discarded. They neither send a message nor set a pending bit.
- R10: While enable is 1, intx_o is 4'b0000. While enable is 0, intx_o follows intx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_we_i | input | 1 | Window dword write strobe |
| tbl_addr_i | input | 12 | Window byte offset |
| tbl_wdata_i | input | 32 | Window write data |
| tbl_rdata_o | output | 32 | Window read data (combinational from tbl_addr_i) |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| ctrl_o | output | 8 | Control byte value |
| event_i | input | NUM_VEC | Per-vector interrupt events |
| unused_i | input | NUM_VEC | Per-vector "vector no longer used" |
| intx_i | input | 4 | Legacy INTA..INTD from the device |
| intx_o | output | 4 | Gated legacy INTx lines |
| msg_valid_o | output | 1 | Message-write request, one cycle per message |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The window read data and intx_o are combinational. The bench checks them a moment after it changes the address, enable or intx_i. A table write, control write or unused pulse takes effect at the edge that samples it, so pending-array reads are made at the falling edge after that edge. An event produces its message at the edge that samples it, so msg_valid_o is checked at the very next falling edge. A replay caused by an unmask needs one edge more, because the new mask must first be registered. Queued replays are then checked at successive falling edges, one vector per cycle.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int unsigned WIN_AW     = 12;
  localparam int unsigned CTRL_EN    = 7;
  localparam int unsigned CTRL_FMASK = 6;

  typedef struct packed {
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] data;
    logic        mask;
  } vec_entry_t;
endpackage

// File: rtl/msix_ctrl_reg.sv
module msix_ctrl_reg
  import msix_pkg::*;
#(
  parameter int INTX_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  logic [INTX_N-1:0] intx_i,
  output logic              enable_o,
  output logic              fmask_o,
  output logic [7:0]        ctrl_o,
  output logic [INTX_N-1:0] intx_o
);
  logic en_q, fm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      fm_q <= 1'b0;
    end else if (we_i) begin
      en_q <= wdata_i[CTRL_EN];
      fm_q <= wdata_i[CTRL_FMASK];
    end
  end

  always_comb begin
    ctrl_o             = '0;
    ctrl_o[CTRL_EN]    = en_q;
    ctrl_o[CTRL_FMASK] = fm_q;
  end

  assign enable_o = en_q;
  assign fmask_o  = fm_q;
  // every legacy line is silenced, not just the first
  assign intx_o   = en_q ? '0 : intx_i;
endmodule

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 4,
  localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [WIN_AW-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [NUM_VEC-1:0]  pend_i,
  output logic [31:0]         rdata_o,
  output vec_entry_t          entries_o [NUM_VEC]
);
  logic       pba_sel;
  logic [6:0] ent_idx;
  logic [1:0] word_sel;

  assign pba_sel  = addr_i[11];
  assign ent_idx  = addr_i[10:4];
  assign word_sel = addr_i[3:2];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
    logic hit;
    assign hit = we_i && !pba_sel && (ent_idx == 7'(v));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entries_o[v].addr_lo <= '0;
        entries_o[v].addr_hi <= '0;
        entries_o[v].data    <= '0;
        entries_o[v].mask    <= 1'b1;
      end else if (hit) begin
        unique case (word_sel)
          2'd0: entries_o[v].addr_lo <= wdata_i;
          2'd1: entries_o[v].addr_hi <= wdata_i;
          2'd2: entries_o[v].data    <= wdata_i;
          2'd3: entries_o[v].mask    <= wdata_i[0];
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (pba_sel) begin
      if (addr_i[10:2] == '0) rdata_o = 32'(pend_i);
    end else if (32'(ent_idx) < NUM_VEC) begin
      unique case (word_sel)
        2'd0: rdata_o = entries_o[ent_idx[IDX_W-1:0]].addr_lo;
        2'd1: rdata_o = entries_o[ent_idx[IDX_W-1:0]].addr_hi;
        2'd2: rdata_o = entries_o[ent_idx[IDX_W-1:0]].data;
        2'd3: rdata_o = {31'b0, entries_o[ent_idx[IDX_W-1:0]].mask};
      endcase
    end
  end
endmodule

// File: rtl/msix_pend_arb.sv
module msix_pend_arb
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               fmask_i,
  input  logic [NUM_VEC-1:0] event_i,
  input  logic [NUM_VEC-1:0] unused_i,
  input  vec_entry_t         entries_i [NUM_VEC],
  output logic [NUM_VEC-1:0] pend_o,
  output logic               msg_valid_o,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o
);
  logic [NUM_VEC-1:0] pend_q, pend_d, ev_live, pend_all, vmask, cand, grant;
  vec_entry_t         sel;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_mask
    assign vmask[v] = entries_i[v].mask;
  end

  assign ev_live  = enable_i ? (event_i & ~unused_i) : '0;
  assign pend_all = pend_q | ev_live;
  assign cand     = pend_all & ~vmask & {NUM_VEC{enable_i & ~fmask_i}};
  // isolate lowest set bit: lowest index wins
  assign grant    = cand & (~cand + NUM_VEC'(1));
  assign pend_d   = pend_all & ~grant & ~unused_i;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (grant[i]) sel = entries_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
    end else begin
      pend_q      <= pend_d;
      msg_valid_o <= |cand;
      if (|cand) begin
        msg_addr_o <= {sel.addr_hi, sel.addr_lo};
        msg_data_o <= sel.data;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/msix_table_ctrl.sv
module msix_table_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int INTX_N  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tbl_we_i,
  input  logic [11:0]        tbl_addr_i,
  input  logic [31:0]        tbl_wdata_i,
  output logic [31:0]        tbl_rdata_o,
  input  logic               ctrl_we_i,
  input  logic [7:0]         ctrl_wdata_i,
  output logic [7:0]         ctrl_o,
  input  logic [NUM_VEC-1:0] event_i,
  input  logic [NUM_VEC-1:0] unused_i,
  input  logic [INTX_N-1:0]  intx_i,
  output logic [INTX_N-1:0]  intx_o,
  output logic               msg_valid_o,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o
);
  logic               enable, fmask;
  logic [NUM_VEC-1:0] pend;
  vec_entry_t         entries [NUM_VEC];

  msix_ctrl_reg #(.INTX_N(INTX_N)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .intx_i   (intx_i),
    .enable_o (enable),
    .fmask_o  (fmask),
    .ctrl_o   (ctrl_o),
    .intx_o   (intx_o)
  );

  msix_vec_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .addr_i    (tbl_addr_i),
    .wdata_i   (tbl_wdata_i),
    .pend_i    (pend),
    .rdata_o   (tbl_rdata_o),
    .entries_o (entries)
  );

  msix_pend_arb #(.NUM_VEC(NUM_VEC)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable),
    .fmask_i     (fmask),
    .event_i     (event_i),
    .unused_i    (unused_i),
    .entries_i   (entries),
    .pend_o      (pend),
    .msg_valid_o (msg_valid_o),
    .msg_addr_o  (msg_addr_o),
    .msg_data_o  (msg_data_o)
  );
endmodule

// File: rtl/msix_table_ctrl_chk.sv
module msix_table_ctrl_chk #(
  parameter int INTX_N = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [7:0]        ctrl_o,
  input logic [INTX_N-1:0] intx_o,
  input logic              msg_valid_o
);
  // R10
  intx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7] |-> intx_o == '0);

  // R5
  msg_needs_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> $past(ctrl_o[7] && !ctrl_o[6]));

  // R6
  fmask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[6] |=> !msg_valid_o);

  // R4
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_o));
endmodule

bind msix_table_ctrl msix_table_ctrl_chk #(.INTX_N(INTX_N)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_o      (ctrl_o),
  .intx_o      (intx_o),
  .msg_valid_o (msg_valid_o)
);

// File: tb/msix_table_ctrl_tb_top.sv
module msix_table_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tbl_we = 1'b0;
  logic [11:0]   tbl_addr = '0;
  logic [31:0]   tbl_wdata = '0;
  logic [31:0]   tbl_rdata;
  logic          ctrl_we = 1'b0;
  logic [7:0]    ctrl_wdata = '0;
  logic [7:0]    ctrl_val;
  logic [NV-1:0] ev = '0;
  logic [NV-1:0] unused = '0;
  logic [3:0]    intx_in = '0;
  logic [3:0]    intx_out;
  logic          mvalid;
  logic [63:0]   maddr;
  logic [31:0]   mdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msix_table_ctrl #(.NUM_VEC(NV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata), .tbl_rdata_o(tbl_rdata),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl_val),
    .event_i(ev), .unused_i(unused), .intx_i(intx_in), .intx_o(intx_out),
    .msg_valid_o(mvalid), .msg_addr_o(maddr), .msg_data_o(mdata)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tbl_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic tbl_rd(logic [11:0] a, output logic [31:0] d);
    tbl_addr = a;
    #1 d = tbl_rdata;
  endtask

  task automatic ctrl_wr(logic [7:0] b);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = b;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic pulse_ev(logic [NV-1:0] m);
    @(negedge clk);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  function automatic logic [63:0] exp_addr(int v);
    return {32'(v), 32'hFEE0_0000 + 32'(v * 16)};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    intx_in = 4'b1010;
    #1;
    check("R1 ctrl", 64'(ctrl_val), 64'h0);
    check("R1 msg", 64'(mvalid), 64'h0);
    tbl_rd(12'h00C, d); check("R1 mask v0", 64'(d), 64'h1);
    tbl_rd(12'h03C, d); check("R1 mask v3", 64'(d), 64'h1);
    tbl_rd(12'h000, d); check("R1 addr_lo", 64'(d), 64'h0);
    tbl_rd(12'h800, d); check("R1 pba", 64'(d), 64'h0);
    check("R10 pass", 64'(intx_out), 64'hA);
  endtask

  task automatic t_table_rw();
    logic [31:0] d;
    tbl_wr(12'h010, 32'h1122_3344);
    tbl_rd(12'h010, d); check("R2 rw", 64'(d), 64'h1122_3344);
    tbl_wr(12'h01B, 32'hA5A5_0011);
    tbl_rd(12'h018, d); check("R2 misaligned", 64'(d), 64'hA5A5_0011);
    tbl_rd(12'h01A, d); check("R2 low bits ignored", 64'(d), 64'hA5A5_0011);
  endtask

  task automatic t_out_of_range();
    logic [31:0] d;
    tbl_wr(12'h040, 32'hDEAD_BEEF);
    tbl_rd(12'h040, d); check("R3 beyond table", 64'(d), 64'h0);
    tbl_rd(12'h000, d); check("R3 v0 untouched", 64'(d), 64'h0);
    tbl_wr(12'h800, 32'hFFFF_FFFF);
    tbl_rd(12'h800, d); check("R3 pba read-only", 64'(d), 64'h0);
  endtask

  task automatic t_ctrl();
    ctrl_wr(8'hFF);
    check("R4 resv bits", 64'(ctrl_val), 64'hC0);
    ctrl_wr(8'h80);
    check("R4 enable only", 64'(ctrl_val), 64'h80);
    intx_in = 4'b1111;
    #1 check("R10 forced off", 64'(intx_out), 64'h0);
  endtask

  task automatic t_deliver();
    for (int v = 0; v < NV; v++) begin
      tbl_wr(12'(v * 16),     32'hFEE0_0000 + 32'(v * 16));
      tbl_wr(12'(v * 16 + 4), 32'(v));
      tbl_wr(12'(v * 16 + 8), 32'h100 + 32'(v));
      tbl_wr(12'(v * 16 + 12), 32'h0);
    end
    check("R7 unmask idle no msg", 64'(mvalid), 64'h0);
    pulse_ev(4'b0100);
    check("R5 valid", 64'(mvalid), 64'h1);
    check("R5 addr", maddr, exp_addr(2));
    check("R5 data", 64'(mdata), 64'h102);
    @(negedge clk);
    check("R5 one cycle", 64'(mvalid), 64'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    ctrl_wr(8'h00);
    #1 check("R10 follow", 64'(intx_out), 64'hF);
    pulse_ev(4'b0001);
    check("R9 no msg", 64'(mvalid), 64'h0);
    tbl_rd(12'h800, d); check("R9 no pending", 64'(d), 64'h0);
    ctrl_wr(8'h80);
    @(negedge clk);
    check("R9 nothing replayed", 64'(mvalid), 64'h0);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    tbl_wr(12'h01C, 32'h1);
    pulse_ev(4'b0010);
    check("R6 vec mask no msg", 64'(mvalid), 64'h0);
    tbl_rd(12'h800, d); check("R6 pending v1", 64'(d), 64'h2);
    ctrl_wr(8'hC0);
    pulse_ev(4'b1001);
    check("R6 fmask no msg", 64'(mvalid), 64'h0);
    tbl_rd(12'h800, d); check("R6 pending fmask", 64'(d), 64'hB);
  endtask

  task automatic t_replay();
    logic [31:0] d;
    ctrl_wr(8'h80);
    @(negedge clk);
    check("R7 first valid", 64'(mvalid), 64'h1);
    check("R7 first data", 64'(mdata), 64'h100);
    check("R7 first addr", maddr, exp_addr(0));
    @(negedge clk);
    check("R7 second valid", 64'(mvalid), 64'h1);
    check("R7 second data", 64'(mdata), 64'h103);
    @(negedge clk);
    check("R7 drained", 64'(mvalid), 64'h0);
    tbl_rd(12'h800, d); check("R7 pending left", 64'(d), 64'h2);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    @(negedge clk);
    unused = 4'b0010;
    @(negedge clk);
    unused = '0;
    tbl_rd(12'h800, d); check("R8 pending dropped", 64'(d), 64'h0);
    tbl_wr(12'h01C, 32'h0);
    @(negedge clk);
    check("R8 no stray msg", 64'(mvalid), 64'h0);
    @(negedge clk);
    check("R8 still quiet", 64'(mvalid), 64'h0);
  endtask

  task automatic t_burst();
    pulse_ev(4'b0110);
    check("R7 burst first", 64'(mdata), 64'h101);
    check("R7 burst first valid", 64'(mvalid), 64'h1);
    @(negedge clk);
    check("R7 burst second", 64'(mdata), 64'h102);
    check("R7 burst second valid", 64'(mvalid), 64'h1);
    @(negedge clk);
    check("R7 burst done", 64'(mvalid), 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_table_rw();
    t_out_of_range();
    t_ctrl();
    t_deliver();
    t_disabled();
    t_masked();
    t_replay();
    t_unused();
    t_burst();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule